// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the vector length configuration instructions of a vector processing unit, in all three operand forms: register-register, register-immediate and immediate-immediate. Decode supplies the destination index, the source index, the source register values and the immediate fields. The block checks the requested element type word for legality and derives the maximum vector length from the configured vector register size. It then picks the new vector length, updates the held length and type state, and returns the new length for writeback to the destination register.

The result is registered. It appears one cycle after a valid request, together with a write enable for the destination register. That response also tells the rest of the vector unit that the start index has been cleared to zero. The element width limit (ELEN) and the vector register size in bytes (VLENB, read-only) are module parameters, and VLEN = VLENB × 8.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first request, the held type reads as a word with only bit 63 set. The held length reads 0 and `rsp_valid` is 0.
- R2: Type word layout: bits 2:0 select the group multiplier, bits 5:3 the element width code, bit 6 the tail policy, bit 7 the mask policy, and bit 63 is the invalid flag. The multiplier codes are 0,1,2,3 → 1,2,4,8 and 5,6,7 → 1/8,1/4,1/2. The element width is 8 << code. A legal request is stored bit for bit, including bits 7:6.
- R3: A request is illegal when any of these holds: the multiplier code is 4; the element width exceeds min(multiplier,1) × ELEN; any of bits 62:8 is set; bit 63 is set. An illegal request stores a type with only bit 63 set and gives a new length of 0.
- R4: The maximum length is floor(VLEN / element width × multiplier), and it is 0 whenever the type is invalid.
- R5: When the source index is nonzero, the new length is the requested length clamped to the maximum length.
- R6: When the source index is zero and the destination index is nonzero, the new length is the maximum length.
- R7: When both indices are zero, the new length is the currently held length clamped to the new maximum length.
- R8: `req_form` selects the operand form. With 0 or 3 (register-register), the type comes from `rs2_value`. With 1 (register-immediate), it comes from all 11 bits of `imm_vtype`. With 2 (immediate-immediate), it comes from bits 9:0 of `imm_vtype`, bit 10 is ignored, and the length comes from the 5-bit `imm_avl`. The immediate-immediate form always behaves as if the source index were nonzero. The other forms take the length from `rs1_value`.
- R9: Each request cycle produces exactly one `rsp_valid` pulse on the next cycle. In that cycle `rsp_vl` equals the new length, `rsp_rd_idx` equals the destination index, and `rsp_rd_we` is 1 unless the index is zero. Without a request the held state does not change. `req_ready` is always 1.
- R10: A request whose type equals the held type leaves the held type unchanged and uses the held configuration for the maximum length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Configuration instruction present |
| req_ready | output | 1 | Always 1 |
| req_form | input | 2 | Operand form: 0/3 reg-reg, 1 reg-imm, 2 imm-imm |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | Source register index |
| rs1_value | input | XLEN | Requested length (register forms) |
| rs2_value | input | XLEN | Requested type (reg-reg form) |
| imm_avl | input | 5 | Requested length (imm-imm form) |
| imm_vtype | input | 11 | Requested type immediate |
| rsp_valid | output | 1 | Result valid; start index cleared |
| rsp_rd_we | output | 1 | Destination write enable |
| rsp_rd_idx | output | 5 | Destination index |
| rsp_vl | output | XLEN | New length for writeback |
| vl_o | output | VLW | Held vector length |
| vtype_o | output | 64 | Held type word |

## Verification
The bench covers each illegality cause on its own: the reserved multiplier code, an element width too wide for a fractional multiplier, a stray high bit, and bit 63 set. A design that missed any of them would keep a nonzero length under a bad configuration. Both-zero requests are run after a long length and then a shorter maximum. This catches a design that reloads the maximum or passes the stale length unclamped. An immediate-immediate request with zero indices and bit 10 of the immediate set catches a design that treats that form's source as zero or leaks the extra bit into the type. Requests that repeat the held type, and idle cycles carrying junk operands, catch spurious state updates.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int VT_W     = 64;
  localparam int VILL_POS = 63;
  localparam logic [VT_W-1:0] VT_INVALID = {1'b1, {(VT_W-1){1'b0}}};

  typedef enum logic [1:0] {
    FORM_RR  = 2'b00,
    FORM_RI  = 2'b01,
    FORM_II  = 2'b10,
    FORM_RR2 = 2'b11
  } form_e;
endpackage

// File: rtl/vcfg_legal.sv
module vcfg_legal #(
  parameter int ELEN = 64
) (
  input  logic [63:8]       vt_hi,
  input  logic [5:0]        vt_lo,
  output logic              legal,
  output logic [3:0]        sew_log,
  output logic signed [3:0] lmul_log
);
  localparam int ELEN_LOG = $clog2(ELEN);

  int cap;

  always_comb begin
    sew_log = 4'd3 + {1'b0, vt_lo[5:3]};
    case (vt_lo[2:0])
      3'd0:    lmul_log = 4'sd0;
      3'd1:    lmul_log = 4'sd1;
      3'd2:    lmul_log = 4'sd2;
      3'd3:    lmul_log = 4'sd3;
      3'd5:    lmul_log = -4'sd3;
      3'd6:    lmul_log = -4'sd2;
      3'd7:    lmul_log = -4'sd1;
      default: lmul_log = 4'sd0;
    endcase
    cap   = ELEN_LOG + ((lmul_log < 0) ? int'(lmul_log) : 0);
    legal = (vt_lo[2:0] != 3'd4) && !vt_hi[63] && (vt_hi[62:8] == '0)
            && (int'(sew_log) <= cap);
  end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
  parameter int VLEN_LOG = 8,
  parameter int VLW      = 9
) (
  input  logic              legal,
  input  logic [3:0]        sew_log,
  input  logic signed [3:0] lmul_log,
  output logic [VLW-1:0]    vlmax
);
  int sh;

  always_comb begin
    sh = VLEN_LOG - int'(sew_log) + int'(lmul_log);
    if (!legal || sh < 0) vlmax = '0;
    else                  vlmax = {{(VLW-1){1'b0}}, 1'b1} << sh;
  end
endmodule

// File: rtl/vcfg_vlsel.sv
module vcfg_vlsel #(
  parameter int XLEN = 64,
  parameter int VLW  = 9
) (
  input  logic [VLW-1:0]  vlmax,
  input  logic [VLW-1:0]  cur_vl,
  input  logic [XLEN-1:0] avl,
  input  logic            rd_zero,
  input  logic            rs1_zero,
  output logic [VLW-1:0]  new_vl
);
  always_comb begin
    if (vlmax == '0)
      new_vl = '0;
    else if (!rs1_zero)
      new_vl = (avl > XLEN'(vlmax)) ? vlmax : avl[VLW-1:0];
    else if (!rd_zero)
      new_vl = vlmax;
    else
      new_vl = (cur_vl > vlmax) ? vlmax : cur_vl;
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ELEN  = 64,
  parameter int VLENB = 32,
  localparam int VLEN_LOG = $clog2(VLENB * 8),
  localparam int VLW      = VLEN_LOG + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_form,
  input  logic [4:0]       rd_idx,
  input  logic [4:0]       rs1_idx,
  input  logic [XLEN-1:0]  rs1_value,
  input  logic [XLEN-1:0]  rs2_value,
  input  logic [4:0]       imm_avl,
  input  logic [10:0]      imm_vtype,
  output logic             rsp_valid,
  output logic             rsp_rd_we,
  output logic [4:0]       rsp_rd_idx,
  output logic [XLEN-1:0]  rsp_vl,
  output logic [VLW-1:0]   vl_o,
  output logic [VT_W-1:0]  vtype_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // held state and response registers
  logic [VT_W-1:0] vtype_q, vtype_d;
  logic [VLW-1:0]  vl_q, vl_d;
  logic            rsp_valid_q, rsp_we_q, rsp_we_d;
  logic [4:0]      rsp_idx_q, rsp_idx_d;

  // operand selection by form
  form_e           form;
  logic [VT_W-1:0] req_vt;
  logic [XLEN-1:0] avl;
  logic            rs1_zero, rd_zero, same_vt;

  always_comb begin
    form = form_e'(req_form);
    case (form)
      FORM_RI: req_vt = {{(VT_W-11){1'b0}}, imm_vtype};
      FORM_II: req_vt = {{(VT_W-10){1'b0}}, imm_vtype[9:0]};
      default: req_vt = VT_W'(rs2_value);
    endcase
    avl      = (form == FORM_II) ? XLEN'(imm_avl) : rs1_value;
    rs1_zero = (form != FORM_II) && (rs1_idx == 5'd0);
    rd_zero  = (rd_idx == 5'd0);
    same_vt  = (req_vt == vtype_q);
  end

  // legality and VLMAX
  logic              req_legal, eff_legal;
  logic [3:0]        sew_log;
  logic signed [3:0] lmul_log;
  logic [VLW-1:0]    vlmax, new_vl;
  logic [VT_W-1:0]   new_vt;

  vcfg_legal #(.ELEN(ELEN)) u_legal (
    .vt_hi    (req_vt[63:8]),
    .vt_lo    (req_vt[5:0]),
    .legal    (req_legal),
    .sew_log  (sew_log),
    .lmul_log (lmul_log)
  );

  assign eff_legal = same_vt ? !vtype_q[VILL_POS] : req_legal;
  assign new_vt    = same_vt ? vtype_q : (req_legal ? req_vt : VT_INVALID);

  vcfg_vlmax #(.VLEN_LOG(VLEN_LOG), .VLW(VLW)) u_vlmax (
    .legal    (eff_legal),
    .sew_log  (sew_log),
    .lmul_log (lmul_log),
    .vlmax    (vlmax)
  );

  vcfg_vlsel #(.XLEN(XLEN), .VLW(VLW)) u_vlsel (
    .vlmax    (vlmax),
    .cur_vl   (vl_q),
    .avl      (avl),
    .rd_zero  (rd_zero),
    .rs1_zero (rs1_zero),
    .new_vl   (new_vl)
  );

  // next state with explicit enable
  always_comb begin
    vtype_d   = vtype_q;
    vl_d      = vl_q;
    rsp_we_d  = rsp_we_q;
    rsp_idx_d = rsp_idx_q;
    if (req_valid) begin
      vtype_d   = new_vt;
      vl_d      = new_vl;
      rsp_we_d  = !rd_zero;
      rsp_idx_d = rd_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vtype_q     <= VT_INVALID;
      vl_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_we_q    <= 1'b0;
      rsp_idx_q   <= '0;
    end else begin
      vtype_q     <= vtype_d;
      vl_q        <= vl_d;
      rsp_valid_q <= req_valid;
      rsp_we_q    <= rsp_we_d;
      rsp_idx_q   <= rsp_idx_d;
    end
  end

  assign req_ready  = 1'b1;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rd_we  = rsp_valid_q & rsp_we_q;
  assign rsp_rd_idx = rsp_idx_q;
  assign rsp_vl     = XLEN'(vl_q);
  assign vl_o       = vl_q;
  assign vtype_o    = vtype_q;

  // R3: an invalid type carries no other bit and no length
  p_vill_clean_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    vtype_q[VILL_POS] |-> (vtype_q[VILL_POS-1:0] == '0) && (vl_q == '0));

  // R9: one response per request, none without
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> !rsp_valid);

  // R9: state holds on idle cycles
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> $stable(vl_q) && $stable(vtype_q));

  // R10: repeating the held type over the register form keeps it
  p_same_keep_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_form == 2'b00 && VT_W'(rs2_value) == vtype_q)
      |=> $stable(vtype_q));
endmodule

// File: tb/sim_vcfg_unit.sv
module sim_vcfg_unit;
  localparam int XLEN = 64;
  localparam int VLW  = 9;
  localparam logic [63:0] VI = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  form;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [63:0] rs1v;
    logic [63:0] rs2v;
    logic [4:0]  iavl;
    logic [10:0] ivt;
    logic [63:0] evl;
    logic [63:0] evt;
  } vec_t;

  // VLEN = 256 bits; expected values follow from the requirements
  localparam vec_t VECS [17] = '{
    '{4'd5,  2'd0, 5'd1, 5'd2, 64'd100,  64'h10,      5'd0,  11'h0,   64'd8,   64'h10},  // R5 R2
    '{4'd6,  2'd0, 5'd1, 5'd0, 64'd0,    64'h13,      5'd0,  11'h0,   64'd64,  64'h13},  // R6
    '{4'd7,  2'd1, 5'd0, 5'd0, 64'd0,    64'h0,       5'd0,  11'h08,  64'd16,  64'h08},  // R7 clamp
    '{4'd7,  2'd1, 5'd0, 5'd0, 64'd0,    64'h0,       5'd0,  11'h0B,  64'd16,  64'h0B},  // R7 keep
    '{4'd8,  2'd2, 5'd3, 5'd0, 64'd0,    64'h0,       5'd31, 11'h4C0, 64'd31,  64'hC0},  // R8 R2
    '{4'd3,  2'd0, 5'd1, 5'd1, 64'd5,    64'h04,      5'd0,  11'h0,   64'd0,   VI},      // R3 code 4
    '{4'd3,  2'd0, 5'd1, 5'd1, 64'd5,    64'h1D,      5'd0,  11'h0,   64'd0,   VI},      // R3 sew too wide
    '{4'd3,  2'd0, 5'd1, 5'd0, 64'd0,    64'h100,     5'd0,  11'h0,   64'd0,   VI},      // R3 high bit
    '{4'd4,  2'd0, 5'd2, 5'd5, 64'd3,    64'h17,      5'd0,  11'h0,   64'd3,   64'h17},  // R4 fractional
    '{4'd10, 2'd0, 5'd2, 5'd5, 64'd1000, 64'h17,      5'd0,  11'h0,   64'd4,   64'h17},  // R10
    '{4'd3,  2'd0, 5'd1, 5'd1, 64'd9,    VI | 64'h10, 5'd0,  11'h0,   64'd0,   VI},      // R3 bit 63
    '{4'd7,  2'd0, 5'd0, 5'd0, 64'd0,    64'h18,      5'd0,  11'h0,   64'd0,   64'h18},  // R7 zero held
    '{4'd5,  2'd0, 5'd4, 5'd7, 64'd0,    64'h18,      5'd0,  11'h0,   64'd0,   64'h18},  // R5 zero avl
    '{4'd4,  2'd1, 5'd6, 5'd9, 64'd200,  64'h0,       5'd0,  11'h03,  64'd200, 64'h03},  // R4 max
    '{4'd8,  2'd1, 5'd1, 5'd1, 64'd4,    64'h0,       5'd0,  11'h110, 64'd0,   VI},      // R8 11-bit imm
    '{4'd8,  2'd2, 5'd0, 5'd0, 64'd0,    64'h0,       5'd20, 11'h12,  64'd20,  64'h12},  // R8 rs1 nonzero
    '{4'd6,  2'd0, 5'd5, 5'd0, 64'd0,    64'h12,      5'd0,  11'h0,   64'd32,  64'h12}   // R6 R10
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_form = '0;
  logic [4:0]       rd_idx = '0, rs1_idx = '0;
  logic [XLEN-1:0]  rs1_value = '0, rs2_value = '0;
  logic [4:0]       imm_avl = '0;
  logic [10:0]      imm_vtype = '0;
  logic             rsp_valid, rsp_rd_we;
  logic [4:0]       rsp_rd_idx;
  logic [XLEN-1:0]  rsp_vl;
  logic [VLW-1:0]   vl_o;
  logic [63:0]      vtype_o;

  int checks = 0;
  int failures = 0;

  always #2ns clk = ~clk;

  vcfg_unit u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_form, .rd_idx, .rs1_idx,
    .rs1_value, .rs2_value, .imm_avl, .imm_vtype, .rsp_valid, .rsp_rd_we,
    .rsp_rd_idx, .rsp_vl, .vl_o, .vtype_o
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #400us;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 during reset
    repeat (3) @(negedge clk);
    chk("R1", "vtype in reset", vtype_o, VI);
    chk("R1", "vl in reset", 64'(vl_o), 64'd0);
    chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "vtype after release", vtype_o, VI);
    chk("R1", "vl after release", 64'(vl_o), 64'd0);
    chk("R9", "req_ready", 64'(req_ready), 64'd1);

    // table walk, back to back requests
    for (int i = 0; i < 17; i++) begin
      req_valid = 1'b1;
      req_form  = VECS[i].form;
      rd_idx    = VECS[i].rd;
      rs1_idx   = VECS[i].rs1;
      rs1_value = VECS[i].rs1v;
      rs2_value = VECS[i].rs2v;
      imm_avl   = VECS[i].iavl;
      imm_vtype = VECS[i].ivt;
      @(negedge clk);
      chk($sformatf("R%0d", VECS[i].tag), $sformatf("vec%0d vl_o", i),
          64'(vl_o), VECS[i].evl);
      chk($sformatf("R%0d", VECS[i].tag), $sformatf("vec%0d vtype_o", i),
          vtype_o, VECS[i].evt);
      chk("R9", $sformatf("vec%0d rsp_vl", i), rsp_vl, VECS[i].evl);
      chk("R9", $sformatf("vec%0d rsp_valid", i), 64'(rsp_valid), 64'd1);
      chk("R9", $sformatf("vec%0d rsp_rd_we", i), 64'(rsp_rd_we),
          64'(VECS[i].rd != 5'd0));
      chk("R9", $sformatf("vec%0d rsp_rd_idx", i), 64'(rsp_rd_idx),
          64'(VECS[i].rd));
    end

    // R9: idle cycles with junk operands change nothing
    req_valid = 1'b0;
    req_form  = 2'b00;
    rd_idx    = 5'd1;
    rs1_idx   = 5'd1;
    rs1_value = 64'd3;
    rs2_value = 64'h04;
    repeat (2) @(negedge clk);
    chk("R9", "idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R9", "idle rsp_rd_we", 64'(rsp_rd_we), 64'd0);
    chk("R9", "idle vl", 64'(vl_o), 64'd32);
    chk("R9", "idle vtype", vtype_o, 64'h12);

    // R1: reset mid-run
    rst_n = 1'b0;
    #1ns;
    chk("R1", "re-reset vtype", vtype_o, VI);
    chk("R1", "re-reset vl", 64'(vl_o), 64'd0);
    chk("R1", "re-reset rsp_valid", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "after re-release vtype", vtype_o, VI);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule